// File: doc/BRIEF.md
# Quad-Precision Round-to-Integer Unit

This block takes one IEEE binary128 operand and returns the nearest integral value under a chosen rounding direction, still in binary128 form. The operand layout is bit 127 sign, bits 126:112 biased exponent (bias 16383) and bits 111:0 fraction. The direction comes from a one-bit selector (`in_r`), a two-bit code (`in_rmc`) and a two-bit dynamic mode (`dyn_rm`). Five directions exist: nearest with ties to even, toward zero, toward +infinity, toward -infinity, and nearest with ties away from zero. The block also reports an invalid flag for signaling NaN inputs, an inexact flag gated by `in_ex`, a five-bit class code for the result, and an illegal-encoding flag for the reserved selector codes.

The datapath is a single registered stage with valid/ready on both sides. An operand is taken on a clock edge where `in_valid` and `in_ready` are both high, and its result appears on the next edge. The result stays on `out_*` until a clock edge where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. That gives full throughput with no bubble and lets back-pressure stall the input directly. The core around the block supplies the operand and the mode fields. It also keeps the status register, raises any traps and writes the result back.

Top module: `qrnd_unit`

## Requirements
- R1: With in_r=0 and in_rmc=00, the operand rounds to nearest with ties away from zero.
- R2: With in_r=0 and in_rmc=11, the direction comes from dyn_rm: 00 nearest-even, 01 toward zero, 10 toward +infinity, 11 toward -infinity.
- R3: With in_r=1, in_rmc picks the direction: 00 nearest-even, 01 toward zero, 10 toward +infinity, 11 toward -infinity. A round-up that carries out of the significand bumps the exponent.
- R4: With in_r=0 and in_rmc=01 or 10, the block rounds nearest-even and sets out_illegal. In every other case out_illegal is 0.
- R5: A signaling NaN has exponent all ones, a nonzero fraction and bit 111 clear. It sets out_invalid, and the result is the operand with bit 111 set. A quiet NaN (bit 111 set) passes through unchanged with out_invalid=0.
- R6: out_inexact equals in_ex AND (result value differs from operand value). With in_ex=0 it is always 0.
- R7: A nonzero finite operand with magnitude below 1 gives a zero or a one as the direction selects, and it keeps the operand's sign. Every finite result keeps the operand's sign.
- R8: Infinities, zeros and finite operands with unbiased exponent 112 or more pass through unchanged, with no flags set.
- R9: out_class is derived from the result: quiet NaN 10001, -infinity 01001, -normal 01000, -zero 10010, +zero 00010, +normal 00100, +infinity 00101.
- R10: in_ready = !out_valid || out_ready. While out_valid=1 and out_ready=0, all outputs hold steady. Results leave in the order the operands were accepted, one result per operand.
- R11: While rst_n is low and after it rises, out_valid is 0 until an operand is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand and mode fields are valid |
| in_ready | output | 1 | Block can accept an operand this cycle |
| in_operand | input | 128 | binary128 operand |
| in_r | input | 1 | Rounding selector bit |
| in_rmc | input | 2 | Rounding mode code |
| in_ex | input | 1 | Inexact reporting enable |
| dyn_rm | input | 2 | Current dynamic rounding mode |
| out_ready | input | 1 | Downstream can take the result |
| out_valid | output | 1 | Result register holds a result |
| out_result | output | 128 | Rounded binary128 result |
| out_invalid | output | 1 | Signaling NaN operand |
| out_inexact | output | 1 | Result differs from operand (gated by in_ex) |
| out_class | output | 5 | Result class code |
| out_illegal | output | 1 | Reserved rounding encoding was used |

## Verification
The assertions assume the downstream side obeys valid/ready and that the mode pins are sampled only at the accepting edge. The stimulus meets both conditions. It changes inputs only away from the clock edge, and it keeps each operand and its fields steady until that operand is accepted. out_ready is held low on a fixed fraction of cycles, so the hold rule gets exercised. The reference arithmetic is exact only for operands widened from double precision with magnitude far below 2^52. Operands outside that range are given as hand-built binary128 words with their results worked out by hand.

// File: rtl/qrnd_pkg.sv
package qrnd_pkg;
  localparam int EXP_W  = 15;
  localparam int FRAC_W = 112;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int BIAS   = 16383;
  localparam int CLS_W  = 5;

  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'd0,
    RM_ZERO      = 3'd1,
    RM_POS       = 3'd2,
    RM_NEG       = 3'd3,
    RM_NEAR_AWAY = 3'd4
  } rmode_e;

  localparam logic [CLS_W-1:0] CLS_QNAN    = 5'b10001;
  localparam logic [CLS_W-1:0] CLS_NEG_INF = 5'b01001;
  localparam logic [CLS_W-1:0] CLS_NEG_NRM = 5'b01000;
  localparam logic [CLS_W-1:0] CLS_NEG_SUB = 5'b11000;
  localparam logic [CLS_W-1:0] CLS_NEG_ZER = 5'b10010;
  localparam logic [CLS_W-1:0] CLS_POS_ZER = 5'b00010;
  localparam logic [CLS_W-1:0] CLS_POS_SUB = 5'b10100;
  localparam logic [CLS_W-1:0] CLS_POS_NRM = 5'b00100;
  localparam logic [CLS_W-1:0] CLS_POS_INF = 5'b00101;
endpackage

// File: rtl/qrnd_mode_dec.sv
module qrnd_mode_dec
  import qrnd_pkg::*;
(
  input  logic       sel_r,
  input  logic [1:0] sel_code,
  input  logic [1:0] dyn_mode,
  output rmode_e     mode,
  output logic       illegal
);
  function automatic rmode_e dir_of(input logic [1:0] c);
    case (c)
      2'b00:   return RM_NEAR_EVEN;
      2'b01:   return RM_ZERO;
      2'b10:   return RM_POS;
      default: return RM_NEG;
    endcase
  endfunction

  always_comb begin
    illegal = 1'b0;
    if (sel_r) begin
      mode = dir_of(sel_code);
    end else begin
      case (sel_code)
        2'b00:   mode = RM_NEAR_AWAY;
        2'b11:   mode = dir_of(dyn_mode);
        default: begin
          mode    = RM_NEAR_EVEN;
          illegal = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/qrnd_core.sv
module qrnd_core
  import qrnd_pkg::*;
(
  input  logic [WORD_W-1:0] op,
  input  rmode_e            mode,
  input  logic              ex_en,
  output logic [WORD_W-1:0] res,
  output logic              invalid,
  output logic              inexact
);
  localparam logic [EXP_W-1:0] EXP_ONE   = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] EXP_HALF  = EXP_W'(BIAS - 1);
  localparam logic [EXP_W-1:0] EXP_WHOLE = EXP_W'(BIAS + FRAC_W);

  logic               sgn;
  logic [EXP_W-1:0]   expf;
  logic [FRAC_W-1:0]  frac;
  assign sgn  = op[WORD_W-1];
  assign expf = op[WORD_W-2 -: EXP_W];
  assign frac = op[FRAC_W-1:0];

  // Alignment of the integer/fraction boundary inside the significand.
  logic [15:0]        sh_w;
  logic [6:0]         sh;
  logic [SIG_W-1:0]   sig, low_mask, half_v, keep, rem;
  logic [SIG_W:0]     unit_v, sum;
  logic               lsb, mid_path, up_mid;

  always_comb begin
    sh_w     = 16'(BIAS + FRAC_W) - {1'b0, expf};
    sh       = sh_w[6:0];
    sig      = {1'b1, frac};
    low_mask = ~({SIG_W{1'b1}} << sh);
    half_v   = SIG_W'(1) << (sh - 7'd1);
    unit_v   = (SIG_W+1)'(1) << sh;
    keep     = sig & ~low_mask;
    rem      = sig & low_mask;
    lsb      = |(keep & unit_v[SIG_W-1:0]);
  end

  always_comb begin
    case (mode)
      RM_NEAR_EVEN: up_mid = (rem > half_v) || ((rem == half_v) && lsb);
      RM_NEAR_AWAY: up_mid = (rem >= half_v);
      RM_POS:       up_mid = (rem != '0) && !sgn;
      RM_NEG:       up_mid = (rem != '0) && sgn;
      default:      up_mid = 1'b0;
    endcase
    sum = {1'b0, keep} + (up_mid ? unit_v : '0);
  end

  logic is_nan, is_zero, below_one, half_exact, above_half, up_small, raw_inx;

  always_comb begin
    is_nan     = (expf == '1) && (frac != '0);
    is_zero    = (expf == '0) && (frac == '0);
    below_one  = expf < EXP_ONE;
    half_exact = (expf == EXP_HALF) && (frac == '0);
    above_half = (expf == EXP_HALF) && (frac != '0);
    mid_path   = (expf != '1) && !is_zero && !below_one && (expf < EXP_WHOLE);
    case (mode)
      RM_NEAR_EVEN: up_small = above_half;
      RM_NEAR_AWAY: up_small = above_half || half_exact;
      RM_POS:       up_small = !sgn;
      RM_NEG:       up_small = sgn;
      default:      up_small = 1'b0;
    endcase
  end

  always_comb begin
    res     = op;
    invalid = 1'b0;
    raw_inx = 1'b0;
    if (expf == '1) begin
      if (is_nan && !frac[FRAC_W-1]) begin
        invalid          = 1'b1;
        res[FRAC_W-1]    = 1'b1;
      end
    end else if (is_zero || expf >= EXP_WHOLE) begin
      res = op;
    end else if (below_one) begin
      raw_inx = 1'b1;
      res     = {sgn, (up_small ? EXP_ONE : '0), {FRAC_W{1'b0}}};
    end else begin
      raw_inx = (rem != '0);
      res     = {sgn, expf + {{(EXP_W-1){1'b0}}, sum[SIG_W]}, sum[FRAC_W-1:0]};
    end
  end

  assign inexact = ex_en && raw_inx;

  // R3
  always_comb begin
    if (mid_path) begin
      hidden_bit_chk: assert (sum[SIG_W] || sum[FRAC_W])
        else $error("rounded significand lost its leading one");
    end
  end
endmodule

// File: rtl/qrnd_classify.sv
module qrnd_classify
  import qrnd_pkg::*;
(
  input  logic [WORD_W-1:0] val,
  output logic [CLS_W-1:0]  cls
);
  logic              sgn;
  logic [EXP_W-1:0]  expf;
  logic [FRAC_W-1:0] frac;
  assign sgn  = val[WORD_W-1];
  assign expf = val[WORD_W-2 -: EXP_W];
  assign frac = val[FRAC_W-1:0];

  always_comb begin
    if (expf == '1)
      cls = (frac != '0) ? CLS_QNAN : (sgn ? CLS_NEG_INF : CLS_POS_INF);
    else if (expf == '0)
      cls = (frac == '0) ? (sgn ? CLS_NEG_ZER : CLS_POS_ZER)
                         : (sgn ? CLS_NEG_SUB : CLS_POS_SUB);
    else
      cls = sgn ? CLS_NEG_NRM : CLS_POS_NRM;
  end
endmodule

// File: rtl/qrnd_unit.sv
module qrnd_unit
  import qrnd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_operand,
  input  logic              in_r,
  input  logic [1:0]        in_rmc,
  input  logic              in_ex,
  input  logic [1:0]        dyn_rm,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_result,
  output logic              out_invalid,
  output logic              out_inexact,
  output logic [CLS_W-1:0]  out_class,
  output logic              out_illegal
);
  localparam logic [EXP_W-1:0] EXP_WHOLE = EXP_W'(BIAS + FRAC_W);

  rmode_e            mode;
  logic              illegal_c, invalid_c, inexact_c;
  logic [WORD_W-1:0] res_c;
  logic [CLS_W-1:0]  cls_c;
  logic              take;

  qrnd_mode_dec u_dec (
    .sel_r    (in_r),
    .sel_code (in_rmc),
    .dyn_mode (dyn_rm),
    .mode     (mode),
    .illegal  (illegal_c)
  );

  qrnd_core u_core (
    .op      (in_operand),
    .mode    (mode),
    .ex_en   (in_ex),
    .res     (res_c),
    .invalid (invalid_c),
    .inexact (inexact_c)
  );

  qrnd_classify u_cls (
    .val (res_c),
    .cls (cls_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      out_result  <= res_c;
      out_invalid <= invalid_c;
      out_inexact <= inexact_c;
      out_class   <= cls_c;
      out_illegal <= illegal_c;
    end
  end

  logic in_is_nan, in_whole;
  assign in_is_nan = (in_operand[WORD_W-2 -: EXP_W] == '1) && (in_operand[FRAC_W-1:0] != '0);
  assign in_whole  = (in_operand[WORD_W-2 -: EXP_W] >= EXP_WHOLE) &&
                     (in_operand[WORD_W-2 -: EXP_W] != '1);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_class)
                                 && $stable(out_inexact) && $stable(out_invalid))
    else $error("output changed while stalled");

  // R5
  nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_invalid |-> (out_result[WORD_W-2 -: EXP_W] == '1) && out_result[FRAC_W-1]
                                 && (out_class == CLS_QNAN))
    else $error("invalid result is not a quiet NaN");

  // R7
  sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !in_is_nan |=> out_result[WORD_W-1] == $past(in_operand[WORD_W-1]))
    else $error("result sign differs from operand sign");

  // R8
  whole_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_whole |=> out_result == $past(in_operand) && !out_inexact && !out_invalid)
    else $error("integral operand altered");

  // R6
  inx_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !in_ex |=> !out_inexact)
    else $error("inexact raised while masked");

  // R4
  illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && (in_r || in_rmc == 2'b00 || in_rmc == 2'b11) |=> !out_illegal)
    else $error("illegal flag on a defined encoding");
endmodule

// File: tb/qrnd_unit_tb.sv
module qrnd_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_operand = '0;
  logic         in_r = 1'b0;
  logic [1:0]   in_rmc = 2'b00;
  logic         in_ex = 1'b0;
  logic [1:0]   dyn_rm = 2'b00;
  logic         out_ready = 1'b0;
  logic         out_valid;
  logic [127:0] out_result;
  logic         out_invalid, out_inexact, out_illegal;
  logic [4:0]   out_class;

  always #(CLK_PERIOD/2) clk = ~clk;

  qrnd_unit u_dut (.*);

  typedef struct {
    logic [127:0] res;
    logic         inv;
    logic         inx;
    logic [4:0]   cls;
    logic         ill;
  } exp_t;

  exp_t   pend_q[$];
  exp_t   pend;
  int     n_checks = 0, n_errors = 0, cyc = 0;
  bit     pushed, stalled = 0, done = 0;
  logic [127:0] held;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [4:0] ref_class(input logic [127:0] v);
    if (v[126:112] == 15'h7fff) return (v[111:0] != 0) ? 5'b10001 : (v[127] ? 5'b01001 : 5'b00101);
    if (v[126:0] == 0) return v[127] ? 5'b10010 : 5'b00010;
    return v[127] ? 5'b01000 : 5'b00100;
  endfunction

  // Widen a nonnegative double to binary128 and attach a sign.
  function automatic logic [127:0] to_q(input real mag, input logic s);
    logic [63:0] b;
    if (mag == 0.0) return {s, 127'b0};
    b = $realtobits(mag);
    return {s, 15'(int'(b[62:52]) - 1023 + 16383), b[51:0], 60'b0};
  endfunction

  // 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf, 4 ties away
  function automatic int sel_mode(input logic r, input logic [1:0] c, input logic [1:0] d);
    if (r) return int'(c);
    if (c == 2'b00) return 4;
    if (c == 2'b11) return int'(d);
    return 0;
  endfunction

  function automatic real rnd(input real x, input int m);
    real f, d;
    case (m)
      1: return (x < 0) ? $ceil(x) : $floor(x);
      2: return $ceil(x);
      3: return $floor(x);
      4: return (x < 0) ? -$floor(-x + 0.5) : $floor(x + 0.5);
      default: begin
        f = $floor(x); d = x - f;
        if (d > 0.5) return f + 1.0;
        if (d < 0.5) return f;
        return ($floor(f / 2.0) * 2.0 == f) ? f : f + 1.0;
      end
    endcase
  endfunction

  task automatic step();
    @(negedge clk);
    out_ready = (cyc % 3) != 2;
    cyc++;
    #1;
    if (stalled && out_valid) chk(out_result == held, "R10 hold", out_result, held);
    if (out_valid && out_ready) begin
      if (pend_q.size() == 0) chk(0, "R10 extra result", out_result, 0);
      else begin
        exp_t e = pend_q.pop_front();
        chk(out_result == e.res, "R1/R2/R3/R7 result", out_result, e.res);
        chk(out_inexact == e.inx, "R6 inexact", 128'(out_inexact), 128'(e.inx));
        chk(out_invalid == e.inv, "R5 invalid", 128'(out_invalid), 128'(e.inv));
        chk(out_illegal == e.ill, "R4 illegal", 128'(out_illegal), 128'(e.ill));
        chk(out_class == e.cls, "R9 class", 128'(out_class), 128'(e.cls));
      end
    end
    stalled = out_valid && !out_ready;
    held    = out_result;
    if (in_valid && in_ready && !pushed) begin
      pend_q.push_back(pend);
      pushed = 1;
    end
    @(posedge clk); #1;
  endtask

  task automatic send(input logic [127:0] op, input logic r, input logic [1:0] c,
                      input logic ex, input logic [1:0] d, input exp_t e);
    in_operand = op; in_r = r; in_rmc = c; in_ex = ex; dyn_rm = d;
    in_valid = 1; pend = e; pushed = 0;
    while (!pushed) step();
    in_valid = 0;
  endtask

  task automatic send_real(input real x, input logic r, input logic [1:0] c,
                           input logic ex, input logic [1:0] d);
    exp_t e;
    real  y;
    logic s = (x < 0);
    y     = rnd(x, sel_mode(r, c, d));
    e.res = to_q((y < 0) ? -y : y, s);
    e.inv = 0;
    e.inx = ex && (y != x);
    e.ill = !r && (c == 2'b01 || c == 2'b10);
    e.cls = ref_class(e.res);
    send(to_q((x < 0) ? -x : x, s), r, c, ex, d, e);
  endtask

  task automatic send_raw(input logic [127:0] op, input logic r, input logic [1:0] c,
                          input logic ex, input logic [127:0] res, input logic inv, input logic inx);
    exp_t e;
    e.res = res; e.inv = inv; e.inx = inx;
    e.ill = !r && (c == 2'b01 || c == 2'b10);
    e.cls = ref_class(res);
    send(op, r, c, ex, 2'b00, e);
  endtask

  real vals[15] = '{0.3, 0.5, 0.7, 1.5, 2.5, 3.5, -0.5, -1.5, -2.5, -0.3, -0.7,
                    7.0, 12345.5, -12346.5, 1.25};

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11
    chk(out_valid == 0, "R11 reset valid", 128'(out_valid), 0);
    chk(in_ready == 1, "R10 ready when empty", 128'(in_ready), 1);
    rst_n = 1;
    @(posedge clk); #1;
    chk(out_valid == 0, "R11 after reset", 128'(out_valid), 0);

    // R1 R2 R3 R4 R6 R7: every encoding and dynamic mode over tie cases
    foreach (vals[i])
      for (int r = 0; r < 2; r++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++)
            send_real(vals[i], r[0], c[1:0], (i + d) % 2 == 0, d[1:0]);

    // R5 signaling and quiet NaN
    send_raw({1'b0, 15'h7fff, 112'h1}, 1, 2'b00, 1,
             {1'b0, 15'h7fff, 1'b1, 111'h1}, 1, 0);
    send_raw({1'b1, 15'h7fff, 1'b1, 111'h5}, 1, 2'b00, 1,
             {1'b1, 15'h7fff, 1'b1, 111'h5}, 0, 0);
    // R8 infinities, zeros, integral operands
    send_raw({1'b0, 15'h7fff, 112'h0}, 0, 2'b00, 1, {1'b0, 15'h7fff, 112'h0}, 0, 0);
    send_raw({1'b1, 15'h7fff, 112'h0}, 1, 2'b10, 1, {1'b1, 15'h7fff, 112'h0}, 0, 0);
    send_raw({1'b1, 127'h0}, 1, 2'b10, 1, {1'b1, 127'h0}, 0, 0);
    send_raw(128'h0, 1, 2'b11, 1, 128'h0, 0, 0);
    send_raw({1'b0, 15'h406F, 112'h1}, 0, 2'b00, 1, {1'b0, 15'h406F, 112'h1}, 0, 0);
    // R3 R1: 2^111 + 0.5, one fraction bit left
    send_raw({1'b0, 15'h406E, 112'h1}, 1, 2'b00, 1, {1'b0, 15'h406E, 112'h0}, 0, 1);
    send_raw({1'b0, 15'h406E, 112'h1}, 0, 2'b00, 1, {1'b0, 15'h406E, 112'h2}, 0, 1);
    send_raw({1'b0, 15'h406E, 112'h1}, 1, 2'b10, 0, {1'b0, 15'h406E, 112'h2}, 0, 0);
    send_raw({1'b1, 15'h406E, 112'h3}, 1, 2'b11, 1, {1'b1, 15'h406E, 112'h4}, 0, 1);

    for (int k = 0; k < 20 && pend_q.size() != 0; k++) step();
    chk(pend_q.size() == 0, "R10 all results delivered", 128'(pend_q.size()), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog R10 actual=%0d expected=0", pend_q.size());
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule